// File: doc/BRIEF.md
# Baud Divisor Factoring Unit

This block takes the frequency of a serial reference clock and a requested line rate, and splits the overall division ratio between two stages. The first stage is the prescaler inside a serial controller, which can divide by 1, 16, 32 or 64 and is selected by a control byte. The second stage is an optional external down-counter whose time constant ranges from 1 to 256. A request carries the 32-bit reference frequency in hertz, a 16-bit line configuration word and a flag saying whether an external counter channel is fitted. Some cycles later the unit reports either success, with the prescaler byte and the time constant, or failure.

All arithmetic is serial. One restoring shift-subtract divider first divides the reference frequency by 75. The quotient is then brought into 16 bits by shifting right, and the requested rate, also expressed in units of 75 baud, is shifted by the same amount. The same divider then forms the ratio of the two. The ratio is factored so that the largest possible power-of-two prescaler is used, and the remainder is checked against what the counter stage can do.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. There is no back-pressure on the result. The unit pulses `done` or `fail` once and then holds the result outputs until the next result pulse.

Top module: `baud_factor_unit`

## Requirements
- R1: A request whose `line_cfg` bits 7, 6 or 5 are set fails. No arithmetic is done for it, and the fail pulse follows two clock edges after the accepting edge.
- R2: The rate code is `line_cfg[12:8]`. The requested rate in units of 75 baud is 2 raised to `line_cfg[11:8]`, multiplied by 3 when `line_cfg[12]` is 1.
- R3: The reference frequency is divided by 75 (integer quotient) and shifted right until its upper 16 bits are zero. The rate in units of 75 is shifted right by the same count, and the ratio is the integer quotient of the two shifted values.
- R4: If the shifted rate is zero, the request fails.
- R5: The prescaler byte is 0xC4 (divide by 64) when the low 6 bits of the ratio are zero. Otherwise it is 0x84 (divide by 32) when the low 5 bits are zero, 0x44 (divide by 16) when the low 4 bits are zero, and 0x04 (divide by 1) in all other cases. The ratio is shifted right by 6, 5, 4 or 0 bits to match.
- R6: With `has_counter` high, a remainder of 1 to 255 gives a time constant equal to the remainder, and 256 gives 0. A remainder of 0 or above 256 makes the request fail.
- R7: With `has_counter` low, the request succeeds only if the remainder is exactly 1. The time constant output then reads 1.
- R8: `done` and `fail` are single-cycle pulses and never high together. On `fail` both result outputs read 0. The result outputs change only in a cycle where `done` or `fail` is high.
- R9: `req_ready` falls after a request is accepted and stays low until the result pulse. `req_valid` has no effect while `req_ready` is low.
- R10: After reset `req_ready` is 1, `done` and `fail` are 0, and both result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| ref_hz | input | 32 | Reference clock frequency in hertz |
| line_cfg | input | 16 | Line configuration word (rate code and option flags) |
| has_counter | input | 1 | An external counter channel is available |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| prescale_reg | output | 8 | Prescaler control byte |
| time_const | output | 8 | Counter time constant (0 means 256) |

## Verification
The vector table uses reference frequencies and rate codes that produce ratios whose lowest set bit sits in different places. This separates each of the four prescaler choices and the order in which they are tried. One pair of vectors differs only in the counter flag, so the counter and no-counter acceptance rules are told apart on the same ratio. Other vectors hit the exact remainder 256 (time constant 0), remainder 257, a ratio of zero, and a rate that shifts down to zero. Each of the three option flag bits is tried on its own. A directed test drives new requests while the unit is busy, then checks that the first result is unchanged, that no second result appears and that the outputs stay held.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam logic [7:0] PRE_X1  = 8'h04;
  localparam logic [7:0] PRE_X16 = 8'h44;
  localparam logic [7:0] PRE_X32 = 8'h84;
  localparam logic [7:0] PRE_X64 = 8'hC4;
  localparam int unsigned OPT_LSB  = 5;
  localparam int unsigned OPT_MSB  = 7;
  localparam int unsigned CODE_LSB = 8;
  localparam int unsigned CODE_W   = 5;
  typedef enum logic [2:0] {S_IDLE, S_REJECT, S_SCALE, S_NORM, S_RATIO} fsm_t;
endpackage

// File: rtl/bdf_divider.sv
module bdf_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] left_q;
  logic [W:0]    trial;

  // shifted partial remainder minus divisor; bit W set means negative
  assign trial = {rem_q, quo[W-1]} - {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo    <= '0;
      left_q <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        quo    <= num;
        den_q  <= den;
        rem_q  <= '0;
        left_q <= CW'(W);
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= {rem_q[W-2:0], quo[W-1]};
          quo   <= {quo[W-2:0], 1'b0};
        end
        if (left_q == CW'(1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bdf_rate_decode.sv
module bdf_rate_decode #(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned OUT_W  = 32
) (
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  units
);
  logic [OUT_W-1:0] pow2;
  assign pow2  = OUT_W'(1) << code[CODE_W-2:0];
  assign units = code[CODE_W-1] ? (pow2 << 1) + pow2 : pow2;
endmodule

// File: rtl/bdf_factor.sv
module bdf_factor
  import bdf_pkg::*;
#(
  parameter int unsigned NORM_W = 16,
  parameter int unsigned TC_W   = 8
) (
  input  logic [NORM_W-1:0] ratio,
  input  logic              has_cnt,
  output logic [7:0]        pre,
  output logic [TC_W-1:0]   tc,
  output logic              ok
);
  localparam int unsigned TC_SPAN = 1 << TC_W;

  logic [NORM_W-1:0] rest;

  // largest power-of-two prescale first
  always_comb begin
    if (ratio[5:0] == 6'd0) begin
      pre  = PRE_X64;
      rest = ratio >> 6;
    end else if (ratio[4:0] == 5'd0) begin
      pre  = PRE_X32;
      rest = ratio >> 5;
    end else if (ratio[3:0] == 4'd0) begin
      pre  = PRE_X16;
      rest = ratio >> 4;
    end else begin
      pre  = PRE_X1;
      rest = ratio;
    end
  end

  always_comb begin
    if (has_cnt) begin
      ok = (rest != '0) && (rest <= NORM_W'(TC_SPAN));
      tc = rest[TC_W-1:0];
    end else begin
      ok = (rest == NORM_W'(1));
      tc = TC_W'(1);
    end
  end
endmodule

// File: rtl/baud_factor_unit.sv
module baud_factor_unit
  import bdf_pkg::*;
#(
  parameter int unsigned REF_W   = 32,
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned NORM_W  = 16,
  parameter int unsigned UNIT_HZ = 75,
  parameter int unsigned TC_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REF_W-1:0] ref_hz,
  input  logic [CFG_W-1:0] line_cfg,
  input  logic             has_counter,
  output logic             done,
  output logic             fail,
  output logic [7:0]       prescale_reg,
  output logic [TC_W-1:0]  time_const
);
  fsm_t             state;
  logic [CFG_W-1:0] cfg_q;
  logic             cnt_q;
  logic [REF_W-1:0] work_clk;
  logic [REF_W-1:0] work_rate;
  logic [REF_W-1:0] rate_units;
  logic             opts_bad;
  logic             too_wide;
  logic             div_start;
  logic [REF_W-1:0] div_num;
  logic [REF_W-1:0] div_den;
  logic [REF_W-1:0] div_quo;
  logic             div_fin;
  logic [7:0]       fac_pre;
  logic [TC_W-1:0]  fac_tc;
  logic             fac_ok;

  assign req_ready = (state == S_IDLE);
  assign opts_bad  = (line_cfg[OPT_MSB:OPT_LSB] != '0);
  assign too_wide  = (work_clk[REF_W-1:NORM_W] != '0);

  always_comb begin
    div_start = 1'b0;
    div_num   = work_clk;
    div_den   = work_rate;
    if (state == S_IDLE) begin
      div_start = req_valid && !opts_bad;
      div_num   = ref_hz;
      div_den   = REF_W'(UNIT_HZ);
    end else if (state == S_NORM) begin
      div_start = !too_wide && (work_rate != '0);
    end
  end

  bdf_divider #(.W(REF_W)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .quo   (div_quo),
    .fin   (div_fin)
  );

  bdf_rate_decode #(.CODE_W(CODE_W), .OUT_W(REF_W)) i_rate (
    .code  (cfg_q[CODE_LSB+CODE_W-1:CODE_LSB]),
    .units (rate_units)
  );

  bdf_factor #(.NORM_W(NORM_W), .TC_W(TC_W)) i_fac (
    .ratio   (div_quo[NORM_W-1:0]),
    .has_cnt (cnt_q),
    .pre     (fac_pre),
    .tc      (fac_tc),
    .ok      (fac_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cfg_q        <= '0;
      cnt_q        <= 1'b0;
      work_clk     <= '0;
      work_rate    <= '0;
      done         <= 1'b0;
      fail         <= 1'b0;
      prescale_reg <= '0;
      time_const   <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            cfg_q <= line_cfg;
            cnt_q <= has_counter;
            state <= opts_bad ? S_REJECT : S_SCALE;
          end
        end
        S_REJECT: begin
          fail         <= 1'b1;
          prescale_reg <= '0;
          time_const   <= '0;
          state        <= S_IDLE;
        end
        S_SCALE: begin
          if (div_fin) begin
            work_clk  <= div_quo;
            work_rate <= rate_units;
            state     <= S_NORM;
          end
        end
        S_NORM: begin
          if (too_wide) begin
            work_clk  <= work_clk >> 1;
            work_rate <= work_rate >> 1;
          end else if (work_rate == '0) begin
            fail         <= 1'b1;
            prescale_reg <= '0;
            time_const   <= '0;
            state        <= S_IDLE;
          end else begin
            state <= S_RATIO;
          end
        end
        S_RATIO: begin
          if (div_fin) begin
            if (fac_ok) begin
              done         <= 1'b1;
              prescale_reg <= fac_pre;
              time_const   <= fac_tc;
            end else begin
              fail         <= 1'b1;
              prescale_reg <= '0;
              time_const   <= '0;
            end
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/baud_factor_chk.sv
module baud_factor_chk #(
  parameter int unsigned TC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            done,
  input logic            fail,
  input logic [7:0]      prescale_reg,
  input logic [TC_W-1:0] time_const
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  p_fail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (prescale_reg == 8'h00 && time_const == '0));

  p_hold_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prescale_reg) |-> (done || fail));

  p_hold_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_const) |-> (done || fail));

  p_legal_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prescale_reg == 8'h04 || prescale_reg == 8'h44 ||
              prescale_reg == 8'h84 || prescale_reg == 8'hC4));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_result_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> req_ready);
endmodule

bind baud_factor_unit baud_factor_chk #(.TC_W(TC_W)) i_chk (.*);

// File: tb/test_baud_factor_unit.sv
`timescale 1ns/1ps
module test_baud_factor_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] ref_hz = '0;
  logic [15:0] line_cfg = '0;
  logic        has_counter = 1'b0;
  logic        done;
  logic        fail;
  logic [7:0]  prescale_reg;
  logic [7:0]  time_const;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  baud_factor_unit i_baud_factor_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .ref_hz       (ref_hz),
    .line_cfg     (line_cfg),
    .has_counter  (has_counter),
    .done         (done),
    .fail         (fail),
    .prescale_reg (prescale_reg),
    .time_const   (time_const)
  );

  // {ref_hz, line_cfg, has_counter, expect_fail, expect_prescale, expect_tc}
  localparam int NVEC = 15;
  localparam logic [65:0] VEC [NVEC] = '{
    {32'd7372800,    16'h1900, 1'b0, 1'b0, 8'hC4, 8'h01}, // shift by 1, ratio 64
    {32'd1843200,    16'h0700, 1'b1, 1'b0, 8'hC4, 8'h03}, // ratio 192
    {32'd1843200,    16'h0700, 1'b0, 1'b1, 8'h00, 8'h00}, // same ratio, no counter
    {32'd1843200,    16'h1900, 1'b0, 1'b0, 8'h44, 8'h01}, // ratio 16
    {32'd1843200,    16'h0900, 1'b1, 1'b0, 8'h44, 8'h03}, // ratio 48
    {32'd1843200,    16'h1920, 1'b1, 1'b1, 8'h00, 8'h00}, // option bit 5
    {32'd7372800,    16'h0700, 1'b1, 1'b0, 8'hC4, 8'h0C}, // ratio 768
    {32'd1228800,    16'h0000, 1'b1, 1'b0, 8'hC4, 8'h00}, // remainder 256
    {32'd1233600,    16'h0000, 1'b1, 1'b1, 8'h00, 8'h00}, // remainder 257
    {32'hFFFFFFFF,   16'h0000, 1'b1, 1'b1, 8'h00, 8'h00}, // rate shifts to 0
    {32'd225,        16'h0000, 1'b1, 1'b0, 8'h04, 8'h03}, // ratio 3
    {32'd7200,       16'h0000, 1'b1, 1'b0, 8'h84, 8'h03}, // ratio 96
    {32'd50,         16'h0000, 1'b1, 1'b1, 8'h00, 8'h00}, // ratio 0
    {32'd1843200,    16'h0780, 1'b1, 1'b1, 8'h00, 8'h00}, // option bit 7
    {32'd1843200,    16'h0740, 1'b1, 1'b1, 8'h00, 8'h00}  // option bit 6
  };

  function automatic string vtag(input int i);
    case (i)
      0, 6:      return "R3";
      1, 7, 8:   return "R6";
      2:         return "R7";
      3, 10, 11: return "R5";
      4:         return "R2";
      9:         return "R4";
      12:        return "R6";
      default:   return "R1";
    endcase
  endfunction

  logic       r_done, r_fail;
  logic [7:0] r_pre, r_tc;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_result();
    r_done = 1'b0;
    r_fail = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done || fail) begin
        r_done = done;
        r_fail = fail;
        r_pre  = prescale_reg;
        r_tc   = time_const;
        return;
      end
    end
  endtask

  task automatic issue(input logic [31:0] hz, input logic [15:0] cfg, input logic hc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    ref_hz      = hz;
    line_cfg    = cfg;
    has_counter = hc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual no completion expected completion");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "req_ready", req_ready, 1);
    chk("R10", "done", done, 0);
    chk("R10", "fail", fail, 0);
    chk("R10", "prescale", prescale_reg, 0);
    chk("R10", "tconst", time_const, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][65:34], VEC[i][33:18], VEC[i][17]);
      chk("R9", "busy after accept", req_ready, 0);
      wait_result();
      chk(vtag(i), $sformatf("vec %0d fail", i), r_fail, VEC[i][16]);
      chk(vtag(i), $sformatf("vec %0d done", i), r_done, !VEC[i][16]);
      chk(vtag(i), $sformatf("vec %0d prescale", i), r_pre, VEC[i][15:8]);
      chk(vtag(i), $sformatf("vec %0d tconst", i), r_tc, VEC[i][7:0]);
      @(negedge clk);
      chk("R8", $sformatf("vec %0d pulse width", i), {done, fail}, 0);
    end

    // R9: requests while busy are ignored; R8: outputs held afterwards
    issue(32'd1843200, 16'h0700, 1'b1);
    req_valid   = 1'b1;
    ref_hz      = 32'd1843200;
    line_cfg    = 16'h1920;
    has_counter = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_result();
    chk("R9", "busy-ignored done", r_done, 1);
    chk("R9", "busy-ignored prescale", r_pre, 8'hC4);
    chk("R9", "busy-ignored tconst", r_tc, 8'h03);
    begin
      int extra = 0;
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        if (done || fail) extra++;
      end
      chk("R9", "no second result", extra, 0);
    end
    chk("R8", "prescale held", prescale_reg, 8'hC4);
    chk("R8", "tconst held", time_const, 8'h03);

    // R1: reject timing, fail two edges after accept
    issue(32'd1843200, 16'h1940, 1'b1);
    chk("R1", "no fail one edge after accept", fail, 0);
    @(negedge clk);
    chk("R1", "fail two edges after accept", fail, 1);

    summary();
    $finish;
  end
endmodule